// File: doc/BRIEF.md
# Sync-Gated Converter Mode Sequencer

This block is the control state machine that sits in front of a converter's measurement engine. A host writes a 3-bit operating mode together with a channel number. The mode can be one idle code, two conversion modes (single and continuous) or three calibration modes. The sequencer starts a built-in conversion timer that stands in for the real modulator and filter, and it counts the configured conversion time of the selected channel. When that time expires, it raises per-channel ready flags and an active-low ready pin. For a calibration, it also captures the engine's result into the matching calibration register and falls back to idle.

An optional gate can hold every operation until an external sync pin is high. With the gate enabled and the pin low, a requested mode is parked and nothing runs. The operation then starts on the first clock at which the pin is seen high, so several converters can begin from a common instant. Host writes to the per-channel calibration registers are accepted only while the sequencer is idle. A write attempted at any other time is discarded and raises a sticky error flag.

Top module: `conv_mode_seq`

## Requirements
- R1: Mode codes are idle=0, continuous=1, single=2, ADC zero-scale self-cal=4, channel zero-scale system cal=6 and channel full-scale system cal=7. A write of code 3 or 5 changes nothing: mode_o, gated_o and any running operation are unaffected.
- R2: With the gate off, a valid non-idle mode write starts the operation at the clock edge that takes the write. The operation completes T edges later, where T is the selected channel's field in conv_time_i (bits ch*TIME_W upward), and a field of 0 counts as 1.
- R3: With sync_en_i high and sync_pin_i low, a requested mode is held with gated_o=1 and no ready flag is set. The full timing of R2 starts at the first edge where sync_pin_i is sampled high. If the pin falls during a running operation, the operation returns to the held state and later restarts from the beginning.
- R4: On completion, single mode sets ready_o[ch] and mode_o returns to 0.
- R5: Continuous mode sets ready_o[ch] on every completion and restarts at once, so a flag is set every T edges until a new mode is written.
- R6: A calibration takes the same T as a conversion on its channel. On completion, adc_result_i is stored: mode 4 writes adc_zs_o, mode 6 writes channel ch of ch_zs_o and mode 7 writes channel ch of ch_fs_o (each DATA_W bits at ch*DATA_W). Then every ready_o bit is set and mode_o returns to 0.
- R7: rdy_n_o is low exactly when at least one ready_o bit is set.
- R8: A pulse on rd_i clears ready_o[rd_ch_i] at the next edge. If a completion sets the same bit at that edge, the set wins.
- R9: A write on cal_wr_i (cal_sel_i 0 = channel zero-scale, 1 = channel full-scale, to channel cal_ch_i) updates the register only while mode_o is 0. Otherwise the write is dropped and cal_err_o goes high and stays high until reset.
- R10: Writing mode 0 ends any held or running operation at once, and no ready flag is set for it.
- R11: After reset, mode_o is 0, gated_o is 0, ready_o is all zero, rdy_n_o is 1, cal_err_o is 0 and all calibration registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_code_i | input | 3 | Requested mode code |
| mode_ch_i | input | CH_W | Channel for the requested mode |
| sync_en_i | input | 1 | Enables the sync gate |
| sync_pin_i | input | 1 | External sync level |
| conv_time_i | input | NUM_CH*TIME_W | Per-channel conversion time in cycles |
| adc_result_i | input | DATA_W | Engine result captured at calibration end |
| cal_wr_i | input | 1 | Host calibration-register write strobe |
| cal_sel_i | input | 1 | 0 zero-scale, 1 full-scale |
| cal_ch_i | input | CH_W | Channel for the calibration write |
| cal_data_i | input | DATA_W | Calibration write data |
| rd_i | input | 1 | Data read strobe |
| rd_ch_i | input | CH_W | Channel being read |
| mode_o | output | 3 | Current mode (0 when idle) |
| gated_o | output | 1 | Mode held by the sync gate |
| ready_o | output | NUM_CH | Per-channel ready flags |
| rdy_n_o | output | 1 | Active-low ready |
| cal_err_o | output | 1 | Sticky dropped-write flag |
| adc_zs_o | output | DATA_W | ADC zero-scale register |
| ch_zs_o | output | NUM_CH*DATA_W | Channel zero-scale registers |
| ch_fs_o | output | NUM_CH*DATA_W | Channel full-scale registers |

## Verification
The sequencer is driven with single and continuous conversions on channels that have different conversion times, one of them zero. This separates an off-by-one in the timer from a wrong channel select. Each calibration mode runs with a distinct result word, which shows that the capture lands in the right register and channel. The sync pin is held low across a request, raised, and also dropped in mid-operation, which tests the hold and the full restart separately. Reads that coincide with a completion, writes of idle during continuous mode, and calibration writes made both while idle and while held test the priorities between the host and the timer.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam logic [2:0] MODE_IDLE  = 3'd0;
  localparam logic [2:0] MODE_CONT  = 3'd1;
  localparam logic [2:0] MODE_SNGL  = 3'd2;
  localparam logic [2:0] MODE_AZS   = 3'd4;
  localparam logic [2:0] MODE_CZS   = 3'd6;
  localparam logic [2:0] MODE_CFS   = 3'd7;

  function automatic logic mode_valid(input logic [2:0] code);
    return (code != 3'd3) && (code != 3'd5);
  endfunction
endpackage

// File: rtl/cms_timer.sv
module cms_timer #(
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [TIME_W-1:0] load_i,
  output logic              done_o
);
  logic [TIME_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (start_i)             cnt_d = (load_i == '0) ? TIME_W'(1) : load_i;
    else if (stop_i)         cnt_d = '0;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == TIME_W'(1));
endmodule

// File: rtl/cms_ctrl.sv
module cms_ctrl
  import cms_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wr_i,
  input  logic [2:0]      mode_code_i,
  input  logic [CH_W-1:0] mode_ch_i,
  input  logic            sync_ok_i,
  input  logic            tm_done_i,
  output logic [2:0]      mode_o,
  output logic            gated_o,
  output logic [CH_W-1:0] ch_o,
  output logic [CH_W-1:0] load_ch_o,
  output logic            start_o,
  output logic            stop_o,
  output logic            fin_conv_o,
  output logic            fin_cal_o
);
  logic [2:0]      mode_q, mode_d;
  logic            gated_q, gated_d;
  logic [CH_W-1:0] ch_q, ch_d;

  always_comb begin
    mode_d     = mode_q;
    gated_d    = gated_q;
    ch_d       = ch_q;
    load_ch_o  = ch_q;
    start_o    = 1'b0;
    stop_o     = 1'b0;
    fin_conv_o = 1'b0;
    fin_cal_o  = 1'b0;
    if (mode_wr_i && mode_valid(mode_code_i)) begin
      mode_d = mode_code_i;
      if (mode_code_i == MODE_IDLE) begin
        gated_d = 1'b0;
        stop_o  = 1'b1;
      end else begin
        ch_d      = mode_ch_i;
        load_ch_o = mode_ch_i;
        gated_d   = !sync_ok_i;
        start_o   = sync_ok_i;
        stop_o    = !sync_ok_i;
      end
    end else if (mode_q != MODE_IDLE) begin
      if (gated_q) begin
        if (sync_ok_i) begin
          gated_d = 1'b0;
          start_o = 1'b1;
        end
      end else if (!sync_ok_i) begin
        gated_d = 1'b1;
        stop_o  = 1'b1;
      end else if (tm_done_i) begin
        if (mode_q == MODE_CONT) begin
          fin_conv_o = 1'b1;
          start_o    = 1'b1;
        end else begin
          fin_conv_o = (mode_q == MODE_SNGL);
          fin_cal_o  = (mode_q != MODE_SNGL);
          mode_d     = MODE_IDLE;
          stop_o     = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_IDLE;
      gated_q <= 1'b0;
      ch_q    <= '0;
    end else begin
      mode_q  <= mode_d;
      gated_q <= gated_d;
      ch_q    <= ch_d;
    end
  end

  assign mode_o  = mode_q;
  assign gated_o = gated_q;
  assign ch_o    = ch_q;
endmodule

// File: rtl/cms_ready.sv
module cms_ready #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_one_i,
  input  logic              set_all_i,
  input  logic [CH_W-1:0]   set_ch_i,
  input  logic              clr_i,
  input  logic [CH_W-1:0]   clr_ch_i,
  output logic [NUM_CH-1:0] flags_o,
  output logic              rdy_n_o
);
  logic [NUM_CH-1:0] flag_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    logic set_b, clr_b;
    assign set_b = set_all_i || (set_one_i && (set_ch_i == CH_W'(g)));
    assign clr_b = clr_i && (clr_ch_i == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               flag_q[g] <= 1'b0;
      else if (set_b || clr_b)  flag_q[g] <= set_b;
    end
  end

  assign flags_o = flag_q;
  assign rdy_n_o = ~|flag_q;
endmodule

// File: rtl/cms_calregs.sv
module cms_calregs
  import cms_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     idle_i,
  input  logic                     host_wr_i,
  input  logic                     host_sel_i,
  input  logic [CH_W-1:0]          host_ch_i,
  input  logic [DATA_W-1:0]        host_data_i,
  input  logic                     fin_cal_i,
  input  logic [2:0]               fin_mode_i,
  input  logic [CH_W-1:0]          fin_ch_i,
  input  logic [DATA_W-1:0]        result_i,
  output logic [DATA_W-1:0]        adc_zs_o,
  output logic [NUM_CH*DATA_W-1:0] ch_zs_o,
  output logic [NUM_CH*DATA_W-1:0] ch_fs_o,
  output logic                     err_o
);
  logic host_ok, host_bad;
  logic err_q;
  logic [DATA_W-1:0] adc_zs_q;

  assign host_ok  = host_wr_i && idle_i;
  assign host_bad = host_wr_i && !idle_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (host_bad) err_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   adc_zs_q <= '0;
    else if (fin_cal_i && fin_mode_i == MODE_AZS) adc_zs_q <= result_i;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit_h, hit_f, zs_en, fs_en;
    logic [DATA_W-1:0] zs_q, fs_q, zs_d, fs_d;
    assign hit_h = host_ok && (host_ch_i == CH_W'(g));
    assign hit_f = fin_cal_i && (fin_ch_i == CH_W'(g));
    assign zs_en = (hit_h && !host_sel_i) || (hit_f && fin_mode_i == MODE_CZS);
    assign fs_en = (hit_h && host_sel_i)  || (hit_f && fin_mode_i == MODE_CFS);
    assign zs_d  = hit_h ? host_data_i : result_i;
    assign fs_d  = hit_h ? host_data_i : result_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        zs_q <= '0;
        fs_q <= '0;
      end else begin
        if (zs_en) zs_q <= zs_d;
        if (fs_en) fs_q <= fs_d;
      end
    end
    assign ch_zs_o[g*DATA_W +: DATA_W] = zs_q;
    assign ch_fs_o[g*DATA_W +: DATA_W] = fs_q;
  end

  assign adc_zs_o = adc_zs_q;
  assign err_o    = err_q;
endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq
  import cms_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TIME_W = 6,
  parameter int DATA_W = 24,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_wr_i,
  input  logic [2:0]               mode_code_i,
  input  logic [CH_W-1:0]          mode_ch_i,
  input  logic                     sync_en_i,
  input  logic                     sync_pin_i,
  input  logic [NUM_CH*TIME_W-1:0] conv_time_i,
  input  logic [DATA_W-1:0]        adc_result_i,
  input  logic                     cal_wr_i,
  input  logic                     cal_sel_i,
  input  logic [CH_W-1:0]          cal_ch_i,
  input  logic [DATA_W-1:0]        cal_data_i,
  input  logic                     rd_i,
  input  logic [CH_W-1:0]          rd_ch_i,
  output logic [2:0]               mode_o,
  output logic                     gated_o,
  output logic [NUM_CH-1:0]        ready_o,
  output logic                     rdy_n_o,
  output logic                     cal_err_o,
  output logic [DATA_W-1:0]        adc_zs_o,
  output logic [NUM_CH*DATA_W-1:0] ch_zs_o,
  output logic [NUM_CH*DATA_W-1:0] ch_fs_o
);
  logic            sync_ok, tm_done, start, stop, fin_conv, fin_cal;
  logic [CH_W-1:0] ch, load_ch;
  logic [TIME_W-1:0] load_val;

  assign sync_ok  = !sync_en_i || sync_pin_i;
  assign load_val = conv_time_i[load_ch*TIME_W +: TIME_W];

  cms_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i), .mode_code_i(mode_code_i),
    .mode_ch_i(mode_ch_i), .sync_ok_i(sync_ok), .tm_done_i(tm_done),
    .mode_o(mode_o), .gated_o(gated_o), .ch_o(ch), .load_ch_o(load_ch),
    .start_o(start), .stop_o(stop), .fin_conv_o(fin_conv), .fin_cal_o(fin_cal)
  );

  cms_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
    .load_i(load_val), .done_o(tm_done)
  );

  cms_ready #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ready (
    .clk(clk), .rst_n(rst_n), .set_one_i(fin_conv), .set_all_i(fin_cal),
    .set_ch_i(ch), .clr_i(rd_i), .clr_ch_i(rd_ch_i),
    .flags_o(ready_o), .rdy_n_o(rdy_n_o)
  );

  cms_calregs #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_cal (
    .clk(clk), .rst_n(rst_n), .idle_i(mode_o == MODE_IDLE),
    .host_wr_i(cal_wr_i), .host_sel_i(cal_sel_i), .host_ch_i(cal_ch_i),
    .host_data_i(cal_data_i), .fin_cal_i(fin_cal), .fin_mode_i(mode_o),
    .fin_ch_i(ch), .result_i(adc_result_i), .adc_zs_o(adc_zs_o),
    .ch_zs_o(ch_zs_o), .ch_fs_o(ch_fs_o), .err_o(cal_err_o)
  );
endmodule

// File: rtl/cms_checker.sv
module cms_checker #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mode_wr_i,
  input logic [2:0]               mode_code_i,
  input logic                     cal_wr_i,
  input logic [2:0]               mode_o,
  input logic                     gated_o,
  input logic [NUM_CH-1:0]        ready_o,
  input logic                     rdy_n_o,
  input logic                     cal_err_o,
  input logic [NUM_CH*DATA_W-1:0] ch_zs_o,
  input logic [NUM_CH*DATA_W-1:0] ch_fs_o
);
  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_i && (mode_code_i == 3'd3 || mode_code_i == 3'd5) && mode_o == 3'd0) |=> (mode_o == 3'd0)); // R1

  AST_GATED_NO_NEW_READY: assert property (@(posedge clk) disable iff (!rst_n)
    gated_o |=> ((ready_o & ~$past(ready_o)) == '0)); // R3

  AST_SINGLE_LEAVES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0 && $past(mode_o) == 3'd2 && !$past(gated_o) && !$past(mode_wr_i)) |-> (ready_o != '0)); // R4

  AST_RDY_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_n_o == ($countones(ready_o) == 0)); // R7

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_wr_i && mode_o != 3'd0 && (gated_o || mode_o < 3'd4)) |=> ($stable(ch_zs_o) && $stable(ch_fs_o))); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err_o |=> cal_err_o); // R9
endmodule

bind conv_mode_seq cms_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i), .mode_code_i(mode_code_i),
  .cal_wr_i(cal_wr_i), .mode_o(mode_o), .gated_o(gated_o), .ready_o(ready_o),
  .rdy_n_o(rdy_n_o), .cal_err_o(cal_err_o), .ch_zs_o(ch_zs_o), .ch_fs_o(ch_fs_o)
);

// File: tb/conv_mode_seq_bench.sv
module conv_mode_seq_bench;
  localparam int NCH = 4;
  localparam int TW  = 6;
  localparam int DW  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [2:0] mode_code = '0;
  logic [1:0] mode_ch = '0;
  logic sync_en = 1'b0, sync_pin = 1'b0;
  logic [NCH*TW-1:0] conv_time;
  logic [DW-1:0] adc_result = '0;
  logic cal_wr = 1'b0, cal_sel = 1'b0;
  logic [1:0] cal_ch = '0;
  logic [DW-1:0] cal_data = '0;
  logic rd = 1'b0;
  logic [1:0] rd_ch = '0;
  logic [2:0] mode_o;
  logic gated_o, rdy_n_o, cal_err_o;
  logic [NCH-1:0] ready_o;
  logic [DW-1:0] adc_zs_o;
  logic [NCH*DW-1:0] ch_zs_o, ch_fs_o;

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  // channel times: ch0=3, ch1=5, ch2=0 (acts as 1), ch3=2
  assign conv_time = {6'd2, 6'd0, 6'd5, 6'd3};

  conv_mode_seq u_conv_mode_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr), .mode_code_i(mode_code),
    .mode_ch_i(mode_ch), .sync_en_i(sync_en), .sync_pin_i(sync_pin),
    .conv_time_i(conv_time), .adc_result_i(adc_result), .cal_wr_i(cal_wr),
    .cal_sel_i(cal_sel), .cal_ch_i(cal_ch), .cal_data_i(cal_data),
    .rd_i(rd), .rd_ch_i(rd_ch), .mode_o(mode_o), .gated_o(gated_o),
    .ready_o(ready_o), .rdy_n_o(rdy_n_o), .cal_err_o(cal_err_o),
    .adc_zs_o(adc_zs_o), .ch_zs_o(ch_zs_o), .ch_fs_o(ch_fs_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode, m_ch, m_left;
  bit m_gated, m_err;
  bit [NCH-1:0] m_ready;
  int m_adczs;
  int m_zs[NCH];
  int m_fs[NCH];

  function automatic int period(input int ch);
    int t;
    t = (conv_time >> (ch*TW)) & 6'h3f;
    return (t == 0) ? 1 : t;
  endfunction

  always @(posedge clk) begin
    bit ok, idle_before, finish;
    bit [NCH-1:0] setv, clrv;
    if (!rst_n) begin
      m_mode = 0; m_ch = 0; m_left = 0; m_gated = 0; m_err = 0; m_ready = '0; m_adczs = 0;
      for (int i = 0; i < NCH; i++) begin m_zs[i] = 0; m_fs[i] = 0; end
    end else begin
      ok = !sync_en || sync_pin;
      idle_before = (m_mode == 0);
      setv = '0;
      clrv = rd ? (NCH'(1) << rd_ch) : '0;
      finish = (m_mode != 0) && !m_gated && (m_left == 1);
      if (mode_wr && mode_code != 3 && mode_code != 5) begin
        m_mode = mode_code;
        m_gated = 0; m_left = 0;
        if (mode_code != 0) begin
          m_ch = mode_ch;
          if (ok) m_left = period(m_ch); else m_gated = 1;
        end
      end else if (m_mode != 0) begin
        if (m_gated) begin
          if (ok) begin m_gated = 0; m_left = period(m_ch); end
        end else if (!ok) begin
          m_gated = 1; m_left = 0;
        end else if (finish) begin
          if (m_mode == 1) begin setv[m_ch] = 1; m_left = period(m_ch); end
          else if (m_mode == 2) begin setv[m_ch] = 1; m_mode = 0; m_left = 0; end
          else begin
            if (m_mode == 4) m_adczs = adc_result;
            else if (m_mode == 6) m_zs[m_ch] = adc_result;
            else m_fs[m_ch] = adc_result;
            setv = '1; m_mode = 0; m_left = 0;
          end
        end else m_left--;
      end
      m_ready = (m_ready & ~clrv) | setv;
      if (cal_wr) begin
        if (idle_before) begin
          if (cal_sel) m_fs[cal_ch] = cal_data; else m_zs[cal_ch] = cal_data;
        end else m_err = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "model mode", mode_o, m_mode);
      chk("R3", "model gated", gated_o, m_gated);
      chk("R5", "model ready", ready_o, m_ready);
      chk("R7", "model rdy_n", rdy_n_o, (m_ready == 0));
      chk("R9", "model err", cal_err_o, m_err);
      chk("R6", "model adc zs", adc_zs_o, m_adczs);
      for (int i = 0; i < NCH; i++) begin
        chk("R6", "model ch zs", ch_zs_o[i*DW +: DW], m_zs[i]);
        chk("R6", "model ch fs", ch_fs_o[i*DW +: DW], m_fs[i]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [2:0] c, input logic [1:0] ch);
    mode_code = c; mode_ch = ch; mode_wr = 1'b1;
    step(1);
    mode_wr = 1'b0;
  endtask

  task automatic rd_once(input logic [1:0] ch);
    rd_ch = ch; rd = 1'b1;
    step(1);
    rd = 1'b0;
  endtask

  task automatic cal_write(input logic sel, input logic [1:0] ch, input logic [DW-1:0] d);
    cal_sel = sel; cal_ch = ch; cal_data = d; cal_wr = 1'b1;
    step(1);
    cal_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R11", "reset mode", mode_o, 0);
    chk("R11", "reset gated", gated_o, 0);
    chk("R11", "reset ready", ready_o, 0);
    chk("R11", "reset rdy_n", rdy_n_o, 1);
    chk("R11", "reset err", cal_err_o, 0);
    chk("R11", "reset regs", {ch_zs_o, ch_fs_o, adc_zs_o}, 0);

    cal_write(1'b0, 2'd1, 24'hABCDEF);
    chk("R9", "idle cal write", ch_zs_o[1*DW +: DW], 24'hABCDEF);
    chk("R9", "no err idle", cal_err_o, 0);

    // single on ch1, T=5
    wr_mode(3'd2, 2'd1);
    chk("R2", "single started", mode_o, 2);
    step(4);
    chk("R2", "single not early", ready_o[1], 0);
    step(1);
    chk("R4", "single ready ch1", ready_o, 4'b0010);
    chk("R4", "single back idle", mode_o, 0);
    chk("R7", "rdy_n low", rdy_n_o, 0);
    rd_once(2'd1);
    chk("R8", "read clears", ready_o, 0);
    chk("R7", "rdy_n high", rdy_n_o, 1);

    wr_mode(3'd5, 2'd2);
    chk("R1", "code5 ignored", mode_o, 0);
    wr_mode(3'd3, 2'd2);
    chk("R1", "code3 ignored", {gated_o, mode_o}, 0);

    // continuous on ch3, T=2
    wr_mode(3'd1, 2'd3);
    step(1);
    chk("R5", "cont not yet", ready_o[3], 0);
    step(1);
    chk("R5", "cont first", ready_o[3], 1);
    rd_once(2'd3);
    chk("R8", "cont cleared", ready_o[3], 0);
    step(1);
    chk("R5", "cont second", ready_o[3], 1);
    wr_mode(3'd0, 2'd0);
    chk("R10", "idle aborts", mode_o, 0);
    rd_once(2'd3);
    step(4);
    chk("R10", "no ready after abort", ready_o, 0);

    // ch2 has time 0 -> one cycle
    wr_mode(3'd2, 2'd2);
    chk("R2", "zero time not instant", ready_o[2], 0);
    step(1);
    chk("R2", "zero time is one", ready_o[2], 1);
    rd_once(2'd2);

    // set and clear in same cycle
    wr_mode(3'd1, 2'd2);
    rd_ch = 2'd2; rd = 1'b1;
    step(1);
    chk("R8", "set wins a", ready_o[2], 1);
    step(1);
    chk("R8", "set wins b", ready_o[2], 1);
    rd = 1'b0;
    wr_mode(3'd0, 2'd0);
    rd_once(2'd2);
    chk("R8", "cleared after stop", ready_o, 0);

    // sync gating, ch0 T=3
    sync_en = 1'b1; sync_pin = 1'b0;
    wr_mode(3'd2, 2'd0);
    chk("R3", "held", {gated_o, mode_o}, {1'b1, 3'd2});
    step(4);
    chk("R3", "still held", gated_o, 1);
    chk("R3", "held no ready", ready_o, 0);
    cal_write(1'b0, 2'd0, 24'h000055);
    chk("R9", "busy write dropped", ch_zs_o[0 +: DW], 0);
    chk("R9", "err set", cal_err_o, 1);
    sync_pin = 1'b1;
    step(1);
    chk("R3", "released", gated_o, 0);
    step(2);
    chk("R3", "not early after sync", ready_o[0], 0);
    step(1);
    chk("R3", "done after sync", ready_o[0], 1);
    rd_once(2'd0);

    // sync drop mid-operation, ch1 T=5
    wr_mode(3'd2, 2'd1);
    step(2);
    sync_pin = 1'b0;
    step(1);
    chk("R3", "drop holds", gated_o, 1);
    step(2);
    sync_pin = 1'b1;
    step(1);
    chk("R3", "restart", gated_o, 0);
    step(4);
    chk("R3", "full restart time", ready_o[1], 0);
    step(1);
    chk("R3", "restart done", ready_o[1], 1);
    rd_once(2'd1);
    sync_en = 1'b0;
    chk("R9", "err sticky", cal_err_o, 1);

    // calibrations
    adc_result = 24'h123456;
    wr_mode(3'd6, 2'd0);
    step(2);
    chk("R6", "cal running", {mode_o, ready_o}, {3'd6, 4'b0000});
    step(1);
    chk("R6", "ch zs captured", ch_zs_o[0 +: DW], 24'h123456);
    chk("R6", "all ready", ready_o, 4'b1111);
    chk("R6", "cal to idle", mode_o, 0);
    adc_result = 24'h0F0F0F;
    wr_mode(3'd4, 2'd3);
    step(1);
    chk("R6", "self cal pending", adc_zs_o, 0);
    step(1);
    chk("R6", "adc zs captured", adc_zs_o, 24'h0F0F0F);
    adc_result = 24'h7A5A5A;
    wr_mode(3'd7, 2'd1);
    step(5);
    chk("R6", "ch fs captured", ch_fs_o[1*DW +: DW], 24'h7A5A5A);
    chk("R7", "rdy_n after cal", rdy_n_o, 0);
    step(2);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule